// File: doc/BRIEF.md
# Reloading Down-Counter Interrupt Timer

A register-mapped countdown timer of 16 or 32 bits for a tick-based system. Software sets a start value and a mode, then enables the counter. While enabled it steps down by one on each pulse of one of two tick-enable inputs; a control bit picks which pulse is used. The tick pulses come from clock logic outside this block.

A tick that finds the count at zero is an underflow. It raises a pending interrupt. The counter then either restarts from the stored start value (periodic mode) or rolls over to all ones (free-running mode). The interrupt line stays high until software writes any value to the clear register.

The expected use is: write the control register with enable low, write the start value, then write control again with enable high. The count takes the start value on that enabling write.

Top module: `dcnt_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word decode on `addr[3:2]`: 0 is the start value, 1 the live count, 2 control, 3 interrupt clear. Control bit 7 is enable, bit 6 is periodic mode and bit 3 is the fast-tick select. All other control bits read as zero.
- R3: A control write that sets bit 7 while the timer is stopped loads the stored start value into the count on the next clock.
- R4: While enabled, the count drops by one on each `tick_fast` pulse when bit 3 is set, or on each `tick_slow` pulse when bit 3 is clear. The unselected tick has no effect.
- R5: In periodic mode, a selected tick at count zero reloads the start value and sets the pending interrupt.
- R6: In free-running mode, a selected tick at count zero sets the count to all ones for the configured width and sets the pending interrupt.
- R7: `irq` is high exactly while an interrupt is pending. A write of any data to the clear word removes it. A clear in the same cycle as an underflow leaves it set.
- R8: A start-value write while enabled makes the next selected tick load that value into the count instead of decrementing.
- R9: The count reads back zero-extended to 32 bits, and the clear word reads as zero.
- R10: Writing zero to control stops counting, and the count then holds through any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Faster count-enable pulse |
| tick_slow | input | 1 | Slower count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt, high while pending |

## Verification
The bench drives the timer at the underflow boundary in both modes. A wrong reload would return a stale start value. A wrong wrap value would appear as 0xFFFFFFFF where a 16-bit counter should read 0xFFFF. Directed tests cover three more hazards:
- A clear written in the same cycle as an underflow. A design that lets the clear win would drop a real interrupt.
- A start-value write while the timer runs. A design that ignores it, or loads it at once, would have the wrong count after the next tick.
- A tick on the unselected input. A design that counts it would run at the wrong rate.

A long random run with short start values then compares every cycle against a reference model.

// File: rtl/dcnt_timer.sv
module dcnt_timer #(
  parameter int CW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_fast,
  input  logic        tick_slow,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam logic [CW-1:0] ALL1 = '1;
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] load_q, cnt_q;
  logic en_q, per_q, fast_q, pend_q, rp_q;

  wire wr_load = wr_en && addr[3:2] == 2'd0;
  wire wr_ctrl = wr_en && addr[3:2] == 2'd2;
  wire wr_clr  = wr_en && addr[3:2] == 2'd3;
  wire start   = wr_ctrl && wdata[7] && !en_q;
  wire tick    = en_q && (fast_q ? tick_fast : tick_slow);
  wire uf      = tick && !rp_q && cnt_q == ZERO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
      pend_q <= 1'b0;
      rp_q   <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata[CW-1:0];
      if (wr_ctrl) begin
        en_q   <= wdata[7];
        per_q  <= wdata[6];
        fast_q <= wdata[3];
      end
      if (start) cnt_q <= load_q;
      else if (tick) begin
        if (rp_q) cnt_q <= load_q;
        else if (cnt_q == ZERO) cnt_q <= per_q ? load_q : ALL1;
        else cnt_q <= cnt_q - ONE;
      end
      if (wr_load && en_q) rp_q <= 1'b1;
      else if (start || tick) rp_q <= 1'b0;
      if (uf) pend_q <= 1'b1;
      else if (wr_clr) pend_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr[3:2])
      2'd0:    rdata = 32'(load_q);
      2'd1:    rdata = 32'(cnt_q);
      2'd2:    rdata = {24'd0, en_q, per_q, 2'b00, fast_q, 3'b000};
      default: rdata = 32'd0;
    endcase
  end

  assign irq = pend_q;

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !start |=> $stable(cnt_q));
  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(load_q));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !rp_q && cnt_q != ZERO |=> cnt_q == $past(cnt_q) - ONE);
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uf && per_q |=> irq && cnt_q == $past(load_q));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uf && !per_q |=> irq && cnt_q == ALL1);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !uf |=> !irq);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_clr |=> irq);
  assert_newload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick && rp_q |=> cnt_q == $past(load_q));
endmodule

// File: tb/dcnt_timer_bench.sv
module dcnt_timer_bench;
  localparam int W = 16;
  localparam logic [W-1:0] MAXV = '1;

  logic clk = 0, rst_n = 0, tf = 0, ts = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_load = 0, m_cnt = 0;
  logic m_en = 0, m_per = 0, m_fast = 0, m_pend = 0, m_rp = 0;

  always #4 clk = ~clk;

  dcnt_timer #(.CW(W)) u_dcnt_timer (
    .clk(clk), .rst_n(rst_n), .tick_fast(tf), .tick_slow(ts), .wr_en(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; we = 0;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic step(input bit w, input logic [3:0] a, input logic [31:0] d,
                      input bit f, input bit s, input string tag);
    logic tk, uf, st;
    logic [W-1:0] n_cnt;
    we = w; addr = a; wdata = d; tf = f; ts = s;
    @(posedge clk);
    tk = m_en && (m_fast ? f : s);
    uf = tk && !m_rp && m_cnt == 0;
    st = w && a[3:2] == 2 && d[7] && !m_en;
    n_cnt = st ? m_load : !tk ? m_cnt : m_rp ? m_load :
            m_cnt == 0 ? (m_per ? m_load : MAXV) : m_cnt - 1'b1;
    if (w && a[3:2] == 0 && m_en) m_rp = 1; else if (st || tk) m_rp = 0;
    if (uf) m_pend = 1; else if (w && a[3:2] == 3) m_pend = 0;
    if (w && a[3:2] == 0) m_load = d[W-1:0];
    if (w && a[3:2] == 2) begin m_en = d[7]; m_per = d[6]; m_fast = d[3]; end
    m_cnt = n_cnt;
    @(negedge clk);
    we = 0; tf = 0; ts = 0;
    rd(4'h4, 32'(m_cnt), tag);
    chk(tag, 32'(irq), 32'(m_pend));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, 0, "R1"); rd(4'h4, 0, "R1"); rd(4'h8, 0, "R1"); rd(4'hC, 0, "R1");
    chk("R1", 32'(irq), 0);
    // R2 control readback, unused bits zero
    step(1, 4'h8, 32'h7F, 0, 0, "R2"); rd(4'h8, 32'h48, "R2");
    // R3 enable loads start value
    step(1, 4'h0, 5, 0, 0, "R3"); rd(4'h0, 5, "R2");
    step(1, 4'h8, 32'hC8, 0, 0, "R3"); rd(4'h4, 5, "R3");
    // R4 fast tick counts, slow ignored
    step(0, 0, 0, 1, 0, "R4"); rd(4'h4, 4, "R4");
    step(0, 0, 0, 0, 1, "R4"); rd(4'h4, 4, "R4");
    repeat (4) step(0, 0, 0, 1, 0, "R4");
    rd(4'h4, 0, "R4"); chk("R5", 32'(irq), 0);
    // R5 periodic reload and interrupt
    step(0, 0, 0, 1, 0, "R5"); rd(4'h4, 5, "R5"); chk("R5", 32'(irq), 1);
    // R7 clear with any data
    step(1, 4'hC, 32'hDEAD, 0, 0, "R7"); chk("R7", 32'(irq), 0);
    repeat (5) step(0, 0, 0, 1, 0, "R7");
    step(1, 4'hC, 0, 1, 0, "R7"); chk("R7", 32'(irq), 1); rd(4'h4, 5, "R7");
    step(1, 4'hC, 0, 0, 0, "R7");
    // R6 wrap mode with slow tick
    step(1, 4'h8, 0, 0, 0, "R6"); step(1, 4'h0, 1, 0, 0, "R6");
    step(1, 4'h8, 32'h80, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R4"); rd(4'h4, 1, "R4");
    step(0, 0, 0, 0, 1, "R6"); step(0, 0, 0, 0, 1, "R6");
    rd(4'h4, 32'h0000FFFF, "R6"); chk("R6", 32'(irq), 1);
    // R9 zero extension and clear word reads zero
    rd(4'h4, 32'h0000FFFF, "R9"); rd(4'hC, 0, "R9");
    // R8 start-value write while running
    step(1, 4'h0, 3, 0, 0, "R8"); rd(4'h4, 32'hFFFF, "R8");
    step(0, 0, 0, 0, 1, "R8"); rd(4'h4, 3, "R8");
    // R10 stop holds count
    step(1, 4'h8, 0, 0, 0, "R10");
    step(0, 0, 0, 1, 1, "R10"); step(0, 0, 0, 1, 1, "R10"); rd(4'h4, 3, "R10");
    // random mix against model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 15);
      logic [3:0] a = 4'($urandom_range(0, 3) << 2);
      logic [31:0] d = (a == 4'h0) ? 32'($urandom_range(0, 6)) : $urandom;
      step(r < 2, a, d, 1'($urandom), 1'($urandom), "RND R4 R5 R6 R7 R8");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule